// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the free-running reference clocks of a multi-output clock generator and its output drivers. It gates every output without glitches, parks it in a safe level when power-down is requested, and brings the outputs back in a fixed order once the PLL is locked again. There are three differential groups (CPU, SRC, DOT) and three single-ended outputs (48 MHz, PCI, REF).

A single input pin has two roles. After reset it is an active-low power-good signal, and all outputs stay parked until it is seen low. From then on the same pin is an active-high power-down request. That request is asynchronous. It only counts when it is sampled high on two successive rising edges of the CPU complement clock. Once a request is qualified, each output stops on its own edge:
- Single-ended outputs stop on their falling edge, so they are held low.
- Differential pairs stop when the complement leg falls. A per-group mode bit then chooses between two parked states: true leg driven high with the complement leg tri-stated, or both legs tri-stated.

A control FSM in the PCI clock domain steps through running, stopping, stopped and waking, and reports this state on a status port. When power-down is released, any pair that was fully tri-stated has its true leg driven high first. The clocks are then released after PLL lock: CPU first, SRC and DOT one PCI cycle later, and single-ended outputs one PCI cycle after that.

Top module: `clkpd_top`

## Requirements
- R1: After reset, while the pin stays high (power not yet good), every output stays parked and the status reads stopped (encoding 2'd2).
- R2: Once the pin has been seen low, holding it high for two or more CPU-complement rising edges stops all outputs, and the status reaches stopped.
- R3: A high pulse on the pin that falls between two CPU-complement rising edges has no effect: the status stays running (2'd0) and the outputs keep toggling.
- R4: Single-ended outputs stop low and only on their own falling edge, so no high pulse shorter than half the source period appears on any of them.
- R5: A stopped differential group whose mode bit is 0 drives the true leg high with its enable at 1, and has its complement enable at 0.
- R6: A stopped differential group whose mode bit is 1 has both leg enables at 0. The mode bit takes effect while the block is stopped. Mode bit i belongs to group i (0 CPU, 1 SRC, 2 DOT).
- R7: On release, the status goes to waking (2'd3), and in that state every true-leg enable is 1 with the true leg high, before any clock toggles.
- R8: After lock, the CPU pair resumes first; the SRC, DOT and single-ended outputs resume later. The requests are spread over two PCI cycles. Once all outputs are running, the status returns to running with all enables at 1.
- R9: The status only moves running→stopping→stopped→waking→running, or from waking back to stopping.
- R10: While waking with the PLL lock flag low, no output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| diff_clk_i | input | N_DIFF | Free-running true clock per differential group (bit 0 CPU) |
| se_clk_i | input | N_SE | Free-running single-ended sources (bit PCI_IDX is PCI) |
| pwr_pin_i | input | 1 | Shared power-good (low) / power-down (high) pin |
| drive_mode_i | input | N_DIFF | Per-group park mode: 0 true high, 1 both tri-stated |
| pll_lock_i | input | 1 | PLL lock flag |
| diff_t_o | output | N_DIFF | Gated true legs |
| diff_c_o | output | N_DIFF | Gated complement legs |
| diff_t_oe_o | output | N_DIFF | True-leg driver enables |
| diff_c_oe_o | output | N_DIFF | Complement-leg driver enables |
| se_o | output | N_SE | Gated single-ended outputs |
| state_o | output | 2 | Sequencer state: 0 running, 1 stopping, 2 stopped, 3 waking |

## Verification
If an enable flop updates on the wrong edge, a single-ended output shows a short high pulse within one source period of the stop. A pair with the wrong mode decoding leaves a driver enable in the wrong level for as long as the block stays stopped. If the request qualifier is wrong, a brief pin glitch stops the clocks within a few PCI cycles. A broken power-good latch keeps the status parked forever after power-good, or releases the outputs too early. If the wake ordering is wrong, the first-toggle times of the CPU and other outputs come in the wrong order within the first few hundred nanoseconds of waking.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
package clkpd_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_STOPPING = 2'd1,
    ST_STOPPED  = 2'd2,
    ST_WAKING   = 2'd3
  } seq_state_e;

  // release step for output index idx: CPU first, other pairs next, single-ended last
  function automatic logic [1:0] rel_slot(int idx, int n_diff);
    if (idx == 0) return 2'd0;
    else if (idx < n_diff) return 2'd1;
    else return 2'd2;
  endfunction
endpackage

// File: rtl/clkpd_qual.sv
`timescale 1ns/1ps
module clkpd_qual (
  input  logic cpu_clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic stop_req_o
);
  logic s1_q, s2_q, pd_mode_q, stop_q;

  // sampled on the CPU complement rising edge
  always_ff @(negedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= 1'b1;
      s2_q      <= 1'b1;
      pd_mode_q <= 1'b0;
      stop_q    <= 1'b1;
    end else begin
      s1_q      <= pin_i;
      s2_q      <= s1_q;
      pd_mode_q <= pd_mode_q | ~s2_q;
      stop_q    <= pd_mode_q ? (s1_q & s2_q) : 1'b1;
    end
  end

  assign stop_req_o = stop_q;
endmodule

// File: rtl/clkpd_gate.sv
`timescale 1ns/1ps
module clkpd_gate #(
  parameter bit DIFF = 1'b0,
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic en_o,
  output logic clk_o
);
  logic [SYNC-1:0] sync_q;
  logic            en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-2:0], run_i};
  end

  generate
    if (DIFF) begin : g_diff
      // true rises as complement falls: switch here so the pair parks high
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= sync_q[SYNC-1];
      end
      assign clk_o = en_q ? clk_i : 1'b1;
    end else begin : g_se
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= sync_q[SYNC-1];
      end
      assign clk_o = clk_i & en_q;
    end
  endgenerate

  assign en_o = en_q;
endmodule

// File: rtl/clkpd_ctrl.sv
`timescale 1ns/1ps
module clkpd_ctrl
  import clkpd_pkg::*;
#(
  parameter int N_DIFF = 3,
  parameter int N_SE   = 3,
  parameter int SYNC   = 2,
  localparam int N_OUT = N_DIFF + N_SE
) (
  input  logic             pci_clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             pll_lock_i,
  input  logic [N_OUT-1:0] en_ack_i,
  output logic [N_OUT-1:0] run_o,
  output logic             tri_phase_o,
  output seq_state_e       state_o
);
  logic [SYNC-1:0]  stop_sq, lock_sq;
  logic [N_OUT-1:0] ack_sq [SYNC];
  seq_state_e       st_q, st_d;
  logic [N_OUT-1:0] run_q, run_d;
  logic [1:0]       step_q, step_d;
  logic             tri_q, tri_d;
  logic             stop_s, lock_s;
  logic [N_OUT-1:0] ack_s;

  always_ff @(posedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_sq <= '1;
      lock_sq <= '0;
      for (int i = 0; i < SYNC; i++) ack_sq[i] <= '0;
    end else begin
      stop_sq   <= {stop_sq[SYNC-2:0], stop_req_i};
      lock_sq   <= {lock_sq[SYNC-2:0], pll_lock_i};
      ack_sq[0] <= en_ack_i;
      for (int i = 1; i < SYNC; i++) ack_sq[i] <= ack_sq[i-1];
    end
  end

  assign stop_s = stop_sq[SYNC-1];
  assign lock_s = lock_sq[SYNC-1];
  assign ack_s  = ack_sq[SYNC-1];

  always_comb begin
    st_d   = st_q;
    run_d  = run_q;
    step_d = step_q;
    tri_d  = tri_q;
    unique case (st_q)
      ST_RUN: if (stop_s) begin
        run_d = '0;
        st_d  = ST_STOPPING;
      end
      ST_STOPPING: if (~|ack_s) begin
        tri_d = 1'b1;
        st_d  = ST_STOPPED;
      end
      ST_STOPPED: if (!stop_s) begin
        tri_d  = 1'b0;
        step_d = 2'd0;
        st_d   = ST_WAKING;
      end
      ST_WAKING: begin
        if (stop_s) begin
          run_d = '0;
          st_d  = ST_STOPPING;
        end else begin
          if (lock_s) begin
            for (int i = 0; i < N_OUT; i++)
              if (step_q == rel_slot(i, N_DIFF)) run_d[i] = 1'b1;
            if (step_q != 2'd3) step_d = step_q + 2'd1;
          end
          if (&ack_s) st_d = ST_RUN;
        end
      end
      default: st_d = ST_STOPPED;
    endcase
  end

  always_ff @(posedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STOPPED;
      run_q  <= '0;
      step_q <= 2'd0;
      tri_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      step_q <= step_d;
      tri_q  <= tri_d;
    end
  end

  assign run_o       = run_q;
  assign tri_phase_o = tri_q;
  assign state_o     = st_q;
endmodule

// File: rtl/clkpd_top.sv
`timescale 1ns/1ps
module clkpd_top
  import clkpd_pkg::*;
#(
  parameter int N_DIFF  = 3,
  parameter int N_SE    = 3,
  parameter int PCI_IDX = 1,
  parameter int SYNC    = 2
) (
  input  logic              rst_ni,
  input  logic [N_DIFF-1:0] diff_clk_i,
  input  logic [N_SE-1:0]   se_clk_i,
  input  logic              pwr_pin_i,
  input  logic [N_DIFF-1:0] drive_mode_i,
  input  logic              pll_lock_i,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_t_oe_o,
  output logic [N_DIFF-1:0] diff_c_oe_o,
  output logic [N_SE-1:0]   se_o,
  output logic [1:0]        state_o
);
  localparam int N_OUT = N_DIFF + N_SE;

  logic             stop_req, tri_phase;
  logic [N_OUT-1:0] run, en;
  seq_state_e       st;

  clkpd_qual u_qual (
    .cpu_clk_i (diff_clk_i[0]),
    .rst_ni    (rst_ni),
    .pin_i     (pwr_pin_i),
    .stop_req_o(stop_req)
  );

  clkpd_ctrl #(.N_DIFF(N_DIFF), .N_SE(N_SE), .SYNC(SYNC)) u_ctrl (
    .pci_clk_i  (se_clk_i[PCI_IDX]),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req),
    .pll_lock_i (pll_lock_i),
    .en_ack_i   (en),
    .run_o      (run),
    .tri_phase_o(tri_phase),
    .state_o    (st)
  );

  for (genvar g = 0; g < N_DIFF; g++) begin : g_diff
    clkpd_gate #(.DIFF(1'b1), .SYNC(SYNC)) u_gate (
      .clk_i (diff_clk_i[g]),
      .rst_ni(rst_ni),
      .run_i (run[g]),
      .en_o  (en[g]),
      .clk_o (diff_t_o[g])
    );
    assign diff_c_o[g]    = en[g] ? ~diff_clk_i[g] : 1'b0;
    assign diff_c_oe_o[g] = en[g];
    assign diff_t_oe_o[g] = ~(tri_phase & drive_mode_i[g]);
  end

  for (genvar s = 0; s < N_SE; s++) begin : g_se
    clkpd_gate #(.DIFF(1'b0), .SYNC(SYNC)) u_gate (
      .clk_i (se_clk_i[s]),
      .rst_ni(rst_ni),
      .run_i (run[N_DIFF+s]),
      .en_o  (en[N_DIFF+s]),
      .clk_o (se_o[s])
    );
  end

  assign state_o = st;
endmodule

// File: rtl/clkpd_chk.sv
`timescale 1ns/1ps
module clkpd_chk #(
  parameter int N_DIFF = 3,
  parameter int N_SE   = 3
) (
  input logic              rst_ni,
  input logic              pci_clk_i,
  input logic [1:0]        state_o,
  input logic [N_SE-1:0]   se_o,
  input logic [N_DIFF-1:0] diff_t_o,
  input logic [N_DIFF-1:0] diff_t_oe_o,
  input logic [N_DIFF-1:0] diff_c_oe_o,
  input logic [N_DIFF-1:0] drive_mode_i
);
  // R4
  se_parked_low_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> (se_o == '0));
  // R5
  diff_true_high_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> (diff_t_o == '1 && diff_c_oe_o == '0));
  // R6
  diff_mode_park_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> (diff_t_oe_o == ~drive_mode_i));
  // R7
  wake_drive_high_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> (diff_t_oe_o == '1));
  // R9
  stopped_exit_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));
  // R9
  run_exit_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1));
  // R9
  stopping_exit_chk: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |=> (state_o == 2'd1 || state_o == 2'd2));
endmodule

bind clkpd_top clkpd_chk #(.N_DIFF(N_DIFF), .N_SE(N_SE)) u_chk (
  .rst_ni      (rst_ni),
  .pci_clk_i   (se_clk_i[PCI_IDX]),
  .state_o     (state_o),
  .se_o        (se_o),
  .diff_t_o    (diff_t_o),
  .diff_t_oe_o (diff_t_oe_o),
  .diff_c_oe_o (diff_c_oe_o),
  .drive_mode_i(drive_mode_i)
);

// File: tb/clkpd_top_tb.sv
`timescale 1ns/1ps
module clkpd_top_tb;
  logic       rst_ni = 1'b0;
  logic [2:0] diff_clk = '0;
  logic [2:0] se_clk = '0;
  logic       pin = 1'b1;
  logic [2:0] mode = 3'b010;
  logic       lock = 1'b0;
  logic [2:0] t_o, c_o, toe, coe, se_o;
  logic [1:0] st;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5  diff_clk[0] = ~diff_clk[0]; // CPU 100 MHz
  always #6  diff_clk[1] = ~diff_clk[1];
  always #4  diff_clk[2] = ~diff_clk[2];
  always #10 se_clk[0]   = ~se_clk[0];
  always #15 se_clk[1]   = ~se_clk[1];   // PCI
  always #14 se_clk[2]   = ~se_clk[2];

  clkpd_top u_dut (
    .rst_ni(rst_ni), .diff_clk_i(diff_clk), .se_clk_i(se_clk), .pwr_pin_i(pin),
    .drive_mode_i(mode), .pll_lock_i(lock), .diff_t_o(t_o), .diff_c_o(c_o),
    .diff_t_oe_o(toe), .diff_c_oe_o(coe), .se_o(se_o), .state_o(st)
  );

  // edge monitors
  real arm_time = 0.0;
  for (genvar i = 0; i < 3; i++) begin : g_dm
    int  cnt = 0;
    real first = -1.0;
    always @(posedge t_o[i]) begin
      cnt++;
      if (first < arm_time) first = $realtime;
    end
  end
  for (genvar i = 0; i < 3; i++) begin : g_sm
    localparam real HALF = (i == 0) ? 10.0 : (i == 1) ? 15.0 : 14.0;
    int  cnt = 0, short_n = 0;
    real first = -1.0, rise = 0.0;
    always @(posedge se_o[i]) begin
      cnt++;
      rise = $realtime;
      if (first < arm_time) first = $realtime;
    end
    always @(negedge se_o[i])
      if ($realtime - rise < HALF - 0.5) short_n++;
  end

  function automatic int total_edges();
    return g_dm[0].cnt + g_dm[1].cnt + g_dm[2].cnt + g_sm[0].cnt + g_sm[1].cnt + g_sm[2].cnt;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    string      req;
    logic [1:0] st;
    bit         full;
    logic [2:0] se, t, toe, coe;
  } exp_t;
  exp_t exp_q[$];
  event snap_ev;

  task automatic expect_snap(string req, logic [1:0] s, bit full,
                             logic [2:0] e_se, logic [2:0] e_t, logic [2:0] e_toe, logic [2:0] e_coe);
    exp_t e;
    e.req = req; e.st = s; e.full = full;
    e.se = e_se; e.t = e_t; e.toe = e_toe; e.coe = e_coe;
    exp_q.push_back(e);
    ->snap_ev;
  endtask

  initial begin
    forever begin
      @(snap_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(st == e.st, e.req, "state", int'(st), int'(e.st));
        check(toe == e.toe, e.req, "true oe", int'(toe), int'(e.toe));
        check(coe == e.coe, e.req, "comp oe", int'(coe), int'(e.coe));
        if (e.full) begin
          check(se_o == e.se, e.req, "se level", int'(se_o), int'(e.se));
          check(t_o == e.t, e.req, "true level", int'(t_o), int'(e.t));
        end
      end
    end
  end

  initial begin
    int e0;
    #20.3 rst_ni = 1'b1;
    #300;
    // R1 R5 R6: parked before power-good, SRC fully tri-stated
    expect_snap("R1", 2'd2, 1, 3'b000, 3'b111, 3'b101, 3'b000);
    e0 = total_edges();
    #500;
    check(total_edges() == e0, "R1", "edges before power-good", total_edges() - e0, 0);
    expect_snap("R5", 2'd2, 1, 3'b000, 3'b111, 3'b101, 3'b000);

    // power-good: pin low, lock still low
    pin = 1'b0;
    #300;
    expect_snap("R7", 2'd3, 1, 3'b000, 3'b111, 3'b111, 3'b000);
    e0 = total_edges();
    #300;
    check(total_edges() == e0, "R10", "edges without lock", total_edges() - e0, 0);

    arm_time = $realtime;
    lock = 1'b1;
    #600;
    expect_snap("R8", 2'd0, 0, 3'b000, 3'b000, 3'b111, 3'b111);
    check(g_dm[0].first >= arm_time, "R8", "cpu resumed", int'(g_dm[0].first >= arm_time), 1);
    check(g_dm[0].first < g_dm[1].first && g_dm[0].first < g_dm[2].first,
          "R8", "cpu before other pairs", int'(g_dm[0].first), int'(g_dm[1].first));
    check(g_dm[0].first < g_sm[0].first && g_dm[0].first < g_sm[1].first && g_dm[0].first < g_sm[2].first,
          "R8", "cpu before single-ended", int'(g_dm[0].first), int'(g_sm[1].first));

    // R3: glitch between CPU-complement rising edges
    @(negedge diff_clk[0]);
    #2.3 pin = 1'b1;
    #4   pin = 1'b0;
    e0 = total_edges();
    #300;
    expect_snap("R3", 2'd0, 0, 3'b000, 3'b000, 3'b111, 3'b111);
    check(total_edges() - e0 > 30, "R3", "edges after glitch", total_edges() - e0, 31);

    // R2 R4: real power-down request
    #0.4 pin = 1'b1;
    #600;
    expect_snap("R2", 2'd2, 1, 3'b000, 3'b111, 3'b101, 3'b000);
    check(g_sm[0].short_n + g_sm[1].short_n + g_sm[2].short_n == 0, "R4", "short se pulses",
          g_sm[0].short_n + g_sm[1].short_n + g_sm[2].short_n, 0);
    e0 = total_edges();
    #200;
    check(total_edges() == e0, "R2", "edges while stopped", total_edges() - e0, 0);

    // R6: mode change while stopped
    mode = 3'b101;
    #1;
    expect_snap("R6", 2'd2, 1, 3'b000, 3'b111, 3'b010, 3'b000);

    // R7: wake with lock present, tri-stated legs driven high first
    pin = 1'b0;
    while (st != 2'd3) #1;
    expect_snap("R7", 2'd3, 1, 3'b000, 3'b111, 3'b111, 3'b000);
    #600;
    expect_snap("R9", 2'd0, 0, 3'b000, 3'b000, 3'b111, 3'b111);
    #50;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule